// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a serial peripheral interface master that software drives through a small byte-addressed register file. Software writes a control byte, a command word, a bit-rate divider and a data word. The engine then shifts the frame out on MOSI and captures MISO. It drives a serial clock and one of several active-low slave-select lines. It raises a level interrupt when the transmit side can take another word or a received frame is waiting.

The master produces clock edges only while a written word is in the shifter. To read a slave, software therefore writes a dummy word and reads the data register once the frame is done. A transmit-only mode lets frames go out without touching the receive flag. An overrun flag records a frame that arrived while the previous one was still unread.

The frame length comes from a 4-bit code in the command word. The code maps to 8 through 16 bits, and also to 20, 24 and 32 bits. Bit order, clock polarity, clock phase and slave-select hold behaviour are also set in the command word.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the status byte (address 1) reads 0x20 with only transmit-empty set. All slave selects are high, the interrupt is low, the serial clock is low and the data register (address 4) reads 0.
- R2: With rate value B (address 2), every serial clock half period lasts B+1 input clock cycles. This includes the time from slave select falling to the first edge.
- R3: The frame length code is command bits 11:8. Codes 7 to 15 give code+1 bits, code 0 gives 20, code 1 gives 24, code 2 gives 32, and codes 3 to 6 give 8 bits.
- R4: When command bit 12 is 0, the frame goes out most significant bit first. When it is 1, it goes out least significant bit first. In both orders the frame is the low bits of the written word.
- R5: Command bit 1 sets the idle level of the serial clock. Command bit 0 set to 0 samples on the leading edge and changes MOSI on the trailing edge. Set to 1, it changes MOSI on the leading edge and samples on the trailing edge.
- R6: Control bit 6 enables the block, and command bits 5:4 pick the slave-select line. If command bit 7 is set, the picked line is low whenever the block is enabled. If bit 7 is clear, the line is low only during a frame. At most one line is ever low, and none is low while the block is disabled.
- R7: A write to the data register clears transmit-empty (status bit 5). While the block is enabled and idle, the word moves into the shifter and transmit-empty is set again. Without such a write no serial clock edge occurs.
- R8: When control bit 1 (transmit-only) is clear, each finished frame sets receive-full (status bit 7) and stores the frame. When control bit 1 is set, receive-full is not raised.
- R9: A read of the data register returns the last received frame, right-justified and zero-extended. The read clears receive-full.
- R10: A frame that finishes while receive-full is set raises overrun (status bit 0) and leaves the stored frame unchanged. Writing 0 to status bit 0 clears overrun, and writing 1 leaves it as it is.
- R11: The interrupt is high when receive-full is set and control bit 7 is set, or when transmit-empty is set and control bit 5 is set. Otherwise it is low.
- R12: Status bit 1 reads 1 while a frame is being shifted and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on data reads) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: two slave-select lines and an 8-bit rate field. Both lines are exercised through the selection field, and the rate values 0 to 5 make the half-period check cheap. MISO is looped back from MOSI, optionally inverted, so each frame both checks the wire order and returns a known receive value. Rate values stay small, so every length class fits into a short run: the 8-to-16 range, 20, 24, 32 and an undefined code. The same holds for all four polarity and phase pairings.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam int WORD_W = 32;
   localparam int LEN_W  = 6;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
   localparam logic [ADDR_W-1:0] A_RATE = 3'd2;
   localparam logic [ADDR_W-1:0] A_CMD  = 3'd3;
   localparam logic [ADDR_W-1:0] A_DATA = 3'd4;

   typedef struct packed {
      logic rx_ie;
      logic enable;
      logic tx_ie;
      logic err_ie;
      logic master;
      logic fault_en;
      logic tx_only;
      logic three_wire;
   } ctrl_t;

   typedef struct packed {
      logic [2:0] rsvd_hi;
      logic       lsb_first;
      logic [3:0] len_code;
      logic       hold_ss;
      logic       rsvd_6;
      logic [1:0] ss_sel;
      logic [1:0] rsvd_lo;
      logic       cpol;
      logic       cpha;
   } cmd_t;

   // Non-linear length code: 7..15 -> code+1, 0/1/2 -> 20/24/32, rest -> 8
   function automatic logic [LEN_W-1:0] frame_bits(input logic [3:0] code);
      case (code)
         4'd0:    frame_bits = 6'd20;
         4'd1:    frame_bits = 6'd24;
         4'd2:    frame_bits = 6'd32;
         4'd3, 4'd4, 4'd5, 4'd6: frame_bits = 6'd8;
         default: frame_bits = {2'b00, code} + 6'd1;
      endcase
   endfunction
endpackage

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   logic [RATE_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (!run || cnt == rate) cnt <= '0;
      else                         cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == rate);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
   import spim_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] tx_word,
   input  logic [LEN_W-1:0]  len,
   input  logic              lsb_first,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              tick,
   input  logic              miso,
   output logic              busy,
   output logic              sck,
   output logic              mosi,
   output logic              frame_done,
   output logic [WORD_W-1:0] rx_word
);
   logic [LEN_W-1:0]  len_l, pad_in, pad_l;
   logic              lsb_l, cpha_l, sck_r;
   logic [LEN_W:0]    edge_n;
   logic [WORD_W-1:0] txs, rxs;
   logic              lead, samp, adv, last;

   assign pad_in = LEN_W'(WORD_W) - len;
   assign pad_l  = LEN_W'(WORD_W) - len_l;
   assign lead   = ~edge_n[0];
   assign samp   = lead ^ cpha_l;
   assign adv    = !samp && !(cpha_l && edge_n == '0);
   assign last   = edge_n == ({len_l, 1'b0} - 7'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; frame_done <= 1'b0; edge_n <= '0;
         len_l <= '0; lsb_l <= 1'b0; cpha_l <= 1'b0; sck_r <= 1'b0;
         txs <= '0; rxs <= '0;
      end else begin
         frame_done <= 1'b0;
         if (start) begin
            busy   <= 1'b1;
            edge_n <= '0;
            len_l  <= len;
            lsb_l  <= lsb_first;
            cpha_l <= cpha;
            sck_r  <= cpol;
            rxs    <= '0;
            txs    <= lsb_first ? tx_word : (tx_word << pad_in);
         end else if (busy && tick) begin
            sck_r  <= ~sck_r;
            edge_n <= edge_n + 1'b1;
            if (samp) rxs <= lsb_l ? {miso, rxs[WORD_W-1:1]} : {rxs[WORD_W-2:0], miso};
            if (adv)  txs <= lsb_l ? (txs >> 1) : (txs << 1);
            if (last) begin
               busy       <= 1'b0;
               frame_done <= 1'b1;
            end
         end
      end
   end

   assign sck     = busy ? sck_r : cpol;
   assign mosi    = lsb_l ? txs[0] : txs[WORD_W-1];
   assign rx_word = lsb_l ? (rxs >> pad_l) : rxs;
endmodule

// File: rtl/spim_regfile.sv
module spim_regfile
   import spim_pkg::*;
#(
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   input  logic              busy,
   input  logic              frame_done,
   input  logic [WORD_W-1:0] rx_word,
   output ctrl_t             ctrl,
   output cmd_t              cmd,
   output logic [RATE_W-1:0] rate,
   output logic [WORD_W-1:0] tx_word,
   output logic              start,
   output logic              tx_empty,
   output logic              rx_full,
   output logic              ovr_flag
);
   logic [WORD_W-1:0] rx_buf;
   logic [7:0]        status;

   assign start  = ctrl.enable && !tx_empty && !busy;
   assign status = {rx_full, 1'b0, tx_empty, 3'b000, busy, ovr_flag};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0; cmd <= '0; rate <= '0; tx_word <= '0; rx_buf <= '0;
         tx_empty <= 1'b1; rx_full <= 1'b0; ovr_flag <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == A_CTRL) ctrl <= ctrl_t'(reg_wdata[7:0]);
         if (reg_wr && reg_addr == A_RATE) rate <= reg_wdata[RATE_W-1:0];
         if (reg_wr && reg_addr == A_CMD)  cmd  <= cmd_t'(reg_wdata[15:0]);
         if (start) tx_empty <= 1'b1;
         if (reg_wr && reg_addr == A_DATA) begin
            tx_word  <= reg_wdata;
            tx_empty <= 1'b0;
         end
         if (reg_wr && reg_addr == A_STAT && !reg_wdata[0]) ovr_flag <= 1'b0;
         if (reg_rd && reg_addr == A_DATA) rx_full <= 1'b0;
         if (frame_done && !ctrl.tx_only) begin
            if (rx_full) ovr_flag <= 1'b1;
            else begin
               rx_buf  <= rx_word;
               rx_full <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      case (reg_addr)
         A_CTRL:  reg_rdata = WORD_W'(ctrl);
         A_STAT:  reg_rdata = WORD_W'(status);
         A_RATE:  reg_rdata = WORD_W'(rate);
         A_CMD:   reg_rdata = WORD_W'(cmd);
         A_DATA:  reg_rdata = rx_buf;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
   import spim_pkg::*;
#(
   parameter int NUM_SS = 2,
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_SS-1:0] ss_n,
   output logic              irq
);
   localparam int SEL_W = 2;

   generate
      if (NUM_SS < 1 || NUM_SS > (1 << SEL_W)) begin : g_bad_ss
         $error("NUM_SS must lie between 1 and 4");
      end
      if (RATE_W < 1 || RATE_W > 16) begin : g_bad_rate
         $error("RATE_W must lie between 1 and 16");
      end
   endgenerate

   ctrl_t             ctrl;
   cmd_t              cmd;
   logic [RATE_W-1:0] rate;
   logic [WORD_W-1:0] tx_word, rx_word;
   logic              start, busy, tick, frame_done;
   logic              tx_empty, rx_full, ovr_flag;
   logic              blk_en, tx_only, ss_on;

   spim_regfile #(.RATE_W(RATE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .busy(busy), .frame_done(frame_done), .rx_word(rx_word),
      .ctrl(ctrl), .cmd(cmd), .rate(rate), .tx_word(tx_word), .start(start),
      .tx_empty(tx_empty), .rx_full(rx_full), .ovr_flag(ovr_flag)
   );

   spim_clkgen #(.RATE_W(RATE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .rate(rate), .tick(tick)
   );

   spim_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
      .len(frame_bits(cmd.len_code)), .lsb_first(cmd.lsb_first),
      .cpol(cmd.cpol), .cpha(cmd.cpha), .tick(tick), .miso(miso),
      .busy(busy), .sck(sck), .mosi(mosi), .frame_done(frame_done),
      .rx_word(rx_word)
   );

   assign blk_en  = ctrl.enable;
   assign tx_only = ctrl.tx_only;
   assign ss_on   = blk_en && (cmd.hold_ss || busy);

   for (genvar i = 0; i < NUM_SS; i++) begin : g_ss
      assign ss_n[i] = !(ss_on && cmd.ss_sel == SEL_W'(i));
   end

   assign irq = (rx_full && ctrl.rx_ie) || (tx_empty && ctrl.tx_ie);
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk
   import spim_pkg::*;
#(
   parameter int NUM_SS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [WORD_W-1:0] reg_wdata,
   input logic [NUM_SS-1:0] ss_n,
   input logic              irq,
   input logic              blk_en,
   input logic              tx_only,
   input logic              tx_empty,
   input logic              rx_full,
   input logic              ovr_flag,
   input logic              frame_done
);
   assert_ss_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ss_n));
   assert_ss_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_en |-> (&ss_n));
   assert_txe_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_DATA) |=> !tx_empty);
   assert_rx_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> $past(frame_done && !tx_only));
   assert_rx_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_full) |-> $past(reg_rd && reg_addr == A_DATA));
   assert_ovr_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !tx_only && rx_full) |=> ovr_flag);
   assert_ovr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovr_flag) |-> $past(reg_wr && reg_addr == A_STAT && !reg_wdata[0]));
   assert_irq_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (rx_full || tx_empty));
endmodule

bind spim_ctrl spim_ctrl_chk #(.NUM_SS(NUM_SS)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ss_n(ss_n), .irq(irq),
   .blk_en(blk_en), .tx_only(tx_only), .tx_empty(tx_empty),
   .rx_full(rx_full), .ovr_flag(ovr_flag), .frame_done(frame_done)
);

// File: tb/spim_ctrl_test.sv
`timescale 1ns/1ps
module spim_ctrl_test;
   import spim_pkg::*;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sck, mosi, miso, irq;
   logic [1:0]  ss_n;
   logic        miso_inv = 1'b0;

   always #2 clk = ~clk;
   assign miso = mosi ^ miso_inv;

   spim_ctrl uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n), .irq(irq)
   );

   int n_tests = 0, n_fail = 0;
   typedef struct { logic [31:0] w; int n; } frame_t;
   frame_t exp_q[$];
   logic mon_cpol = 1'b0, mon_cpha = 1'b0;
   int   mon_half = 1;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int len_of(int code);
      if (code == 0) return 20;
      if (code == 1) return 24;
      if (code == 2) return 32;
      if (code < 7)  return 8;
      return code + 1;
   endfunction

   function automatic logic [31:0] mask_of(int n);
      return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
   endfunction

   function automatic frame_t wire_of(logic [31:0] d, int n, bit lsb);
      frame_t f;
      f.w = '0; f.n = n;
      for (int i = 0; i < n; i++) f.w = {f.w[30:0], (lsb ? d[i] : d[n-1-i])};
      return f;
   endfunction

   // Monitor: rebuilds each frame from the pins and scores it against the queue
   logic        prev_sck = 1'b0, prev_act = 1'b0, act;
   int          bits = 0, gap = 0;
   logic [31:0] obs = '0;
   bit          gap_bad = 1'b0;
   frame_t      got;
   always @(negedge clk) begin
      act = ~&ss_n;
      if (rst_n) begin
         if (act && !prev_act) begin
            bits = 0; obs = '0; gap = 0; gap_bad = 1'b0;
         end else if (act || prev_act) begin
            gap++;
            if (sck !== prev_sck) begin
               if (gap != mon_half) gap_bad = 1'b1;
               gap = 0;
               if (((prev_sck == mon_cpol) ? 1'b1 : 1'b0) ^ mon_cpha) begin
                  obs = {obs[30:0], mosi};
                  bits++;
               end
            end
         end
         if (prev_act && !act && bits > 0) begin
            if (exp_q.size() == 0) chk("R7", "unexpected frame", 32'(bits), 0);
            else begin
               got = exp_q.pop_front();
               chk("R3", "bit count", 32'(bits), 32'(got.n));
               chk("R4", "wire bits", obs, got.w);
               chk("R2", "half period error", 32'(gap_bad), 0);
            end
         end
      end
      prev_sck = sck;
      prev_act = act;
   end

   task automatic wr(logic [2:0] a, logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      #0.5 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      do rd(A_STAT, s); while (s[1] || !s[5]);
      repeat (2) @(negedge clk);
   endtask

   function automatic logic [31:0] cmd_of(int code, bit lsb, bit cpol, bit cpha, int sel, bit hold);
      logic [31:0] c = '0;
      c[12] = lsb; c[11:8] = 4'(code); c[7] = hold;
      c[5:4] = 2'(sel); c[1] = cpol; c[0] = cpha;
      return c;
   endfunction

   task automatic send(logic [31:0] d, int code, bit lsb, bit cpol, bit cpha,
                       int rate, int sel, bit txonly, bit probe);
      logic [31:0] s;
      mon_cpol = cpol; mon_cpha = cpha; mon_half = rate + 1;
      wr(A_RATE, 32'(rate));
      wr(A_CMD, cmd_of(code, lsb, cpol, cpha, sel, 1'b0));
      wr(A_CTRL, txonly ? 32'h4A : 32'h48);
      exp_q.push_back(wire_of(d, len_of(code), lsb));
      wr(A_DATA, d);
      if (probe) begin
         repeat (2) @(negedge clk);
         rd(A_STAT, s);
         chk("R12", "busy during frame", 32'(s[1]), 1);
      end
      wait_idle();
      chk("R5", "idle clock level", 32'(sck), 32'(cpol));
   endtask

   task automatic rx_expect(logic [31:0] d, int code, string req);
      logic [31:0] v;
      rd(A_DATA, v);
      chk(req, "received word", v, (miso_inv ? ~d : d) & mask_of(len_of(code)));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int          edges;
      logic        s0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_STAT, v);  chk("R1", "status", v, 32'h20);
      chk("R1", "slave selects", 32'(ss_n), 32'h3);
      chk("R1", "irq", 32'(irq), 0);
      chk("R1", "sck", 32'(sck), 0);
      rd(A_DATA, v);  chk("R1", "data", v, 0);

      // R7 no clock without a data write; R6 no select when idle and not held
      wr(A_CTRL, 32'h48);
      edges = 0; s0 = sck;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (sck !== s0) edges++;
      end
      chk("R7", "edges without write", 32'(edges), 0);
      chk("R6", "select idle unheld", 32'(ss_n), 32'h3);

      // Frames across lengths, orders and modes (R2..R5, R8, R9)
      send(32'h0000_00A5, 7, 0, 0, 0, 0, 0, 0, 0);   rx_expect(32'hA5, 7, "R9");
      rd(A_STAT, v); chk("R9", "rx full cleared", 32'(v[7]), 0);
      miso_inv = 1'b1;
      send(32'h0000_C3A1, 15, 1, 1, 1, 1, 0, 0, 0);  rx_expect(32'hC3A1, 15, "R4");
      miso_inv = 1'b0;
      send(32'h000A_BCDE, 0, 0, 0, 1, 2, 1, 0, 0);   rx_expect(32'hABCDE, 0, "R3");
      send(32'h005A_0F96, 1, 1, 1, 0, 0, 0, 0, 0);   rx_expect(32'h5A0F96, 1, "R3");
      send(32'hDEAD_BEEF, 2, 0, 0, 0, 3, 1, 0, 0);   rx_expect(32'hDEADBEEF, 2, "R3");
      send(32'h0000_09C3, 11, 1, 0, 1, 0, 0, 0, 0);  rx_expect(32'h9C3, 11, "R4");
      send(32'h0000_0136, 4, 0, 1, 1, 1, 0, 0, 0);   rx_expect(32'h136, 4, "R3");
      send(32'h0000_003C, 7, 0, 0, 0, 5, 0, 0, 1);   rx_expect(32'h3C, 7, "R8");
      rd(A_STAT, v); chk("R12", "busy after frame", 32'(v[1]), 0);

      // R10 overrun
      send(32'h11, 7, 0, 0, 0, 0, 0, 0, 0);
      rd(A_STAT, v); chk("R8", "rx full set", v, 32'hA0);
      send(32'h22, 7, 0, 0, 0, 0, 0, 0, 0);
      rd(A_STAT, v); chk("R10", "overrun status", v, 32'hA1);
      rd(A_DATA, v); chk("R10", "stored frame kept", v, 32'h11);
      wr(A_STAT, 32'h01);
      rd(A_STAT, v); chk("R10", "write 1 keeps", v, 32'h21);
      wr(A_STAT, 32'h00);
      rd(A_STAT, v); chk("R10", "write 0 clears", v, 32'h20);

      // R8 transmit-only
      send(32'h77, 7, 0, 0, 0, 0, 0, 1, 0);
      rd(A_STAT, v); chk("R8", "tx-only no rx full", v, 32'h20);

      // R11 interrupt
      wr(A_CTRL, 32'h68); chk("R11", "irq tx empty", 32'(irq), 1);
      wr(A_CTRL, 32'hC8); chk("R11", "irq no rx", 32'(irq), 0);
      send(32'h5B, 7, 0, 0, 0, 0, 0, 0, 0);
      wr(A_CTRL, 32'hC8); chk("R11", "irq rx full", 32'(irq), 1);
      rd(A_DATA, v);      chk("R11", "irq after read", 32'(irq), 0);

      // R6 held select
      wr(A_CMD, cmd_of(7, 0, 0, 0, 1, 1'b1));
      wr(A_CTRL, 32'h48); chk("R6", "held select line 1", 32'(ss_n), 32'h1);
      wr(A_CTRL, 32'h08); chk("R6", "disabled", 32'(ss_n), 32'h3);
      wr(A_CMD, cmd_of(7, 0, 0, 0, 0, 1'b1));
      wr(A_CTRL, 32'h48); chk("R6", "held select line 0", 32'(ss_n), 32'h2);
      wr(A_CTRL, 32'h08);
      repeat (2) @(negedge clk);

      chk("R4", "frames left unseen", 32'(exp_q.size()), 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule